// File: doc/BRIEF.md
# Interleaved Memory Bank Arbiter

This block fronts a word-addressed memory that is split into sixteen independent banks. Consecutive word addresses land in consecutive banks. A client hands over one vector command at a time: a start address, a constant stride (any value, including zero and strides that wrap past the top of memory), an element count and a read/write flag. The block walks the addresses itself and issues at most one element per clock. Write data comes in on a valid/ready stream and read data goes out on one.

After a bank takes an access it stays busy for a fixed number of cycles, four by default. An element whose bank is still busy waits in place, and the elements behind it wait too, so order is always kept. With sixteen banks and a four-cycle occupancy, most strides stream at one word per clock. Strides that revisit a bank too soon are slower: a stride of 8 (mod 16) reaches two banks per four cycles, and a stride of 16 or 0 reaches one. A plain register array stands in for the storage cells. A one-cycle completion pulse tells the client when the whole vector has been issued.

Top module: `banked_vector_mem`

## Requirements
- R1: The bank of an element is the low 4 bits of its word address. A bank that accepts an element at clock edge t accepts no other element before edge t+4.
- R2: Element k of a command targets word address (start + k*stride) mod 256. Elements are issued strictly in order of k, and read data returns in that order, each value being the word last written at that address.
- R3: For a stride whose bank sequence repeats no bank within any 4 consecutive elements (for example 1, 3, 4 or 255), a read of N elements with read data always accepted issues one element per cycle. The completion pulse is seen N cycles after the command is accepted.
- R4: For a stride of 8 (mod 16), a read of N elements completes 1 + 4*((N-1)/2) + ((N-1) mod 2) cycles after acceptance. For a stride of 0 (mod 16), it completes 4N-3 cycles after acceptance.
- R5: `done` is high for exactly one cycle, in the cycle after the last element issues. In that same cycle `cmd_ready` is high again.
- R6: A command is taken on a clock edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low from the next cycle until the vector completes. A command presented while `cmd_ready` is low is dropped and causes no access.
- R7: During a write vector, `wd_ready` is high exactly when the current element's bank is free. The word is stored on an edge where `wd_valid` and `wd_ready` are both high. An edge without `wd_valid` issues nothing and stores nothing. `wd_ready` stays low during read vectors.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high, `rd_data` holds its value, and no further element issues.
- R9: A synchronous active-low reset leaves `cmd_ready` high, `rd_valid` low and `done` low, abandons any vector in progress, and marks all banks free.
- R10: Address generation wraps modulo the 256-word memory size, in both the upward and the downward (stride 255) direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Vector command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_write | input | 1 | 1 = write vector, 0 = read vector |
| cmd_start | input | 8 | First word address |
| cmd_stride | input | 8 | Address increment per element, modulo 256 |
| cmd_len | input | 8 | Element count minus one |
| wd_valid | input | 1 | Write word offered |
| wd_ready | output | 1 | Current write element can issue this cycle |
| wd_data | input | 16 | Write word |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Client takes the read word |
| rd_data | output | 16 | Read word |
| done | output | 1 | One-cycle pulse after the last element issues |

## Verification
An element issued on edge t appears on `rd_data`/`rd_valid` after that same edge. The completion pulse also follows the edge of the last issue. So the accept edge counts as cycle 0, and every result is read at the falling edge after the edge that produced it. The bench counts falling edges from the accept edge. It compares that count with the R3/R4 formulas for each stride in its table, and checks each read word against the address sequence it computes itself. Between table rows the bench waits more than the bank occupancy, so every row starts with all banks free and the expected cycle counts stay exact.

// File: rtl/bvm_pkg.sv
// Shared definitions for the banked vector memory.
// Assumes: nothing beyond IEEE 1800-2017.
package bvm_pkg;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;

    // Bank index of a word address: its low bits select the bank.
    function automatic int unsigned bank_sel_w(input int unsigned banks);
        return (banks <= 1) ? 1 : $clog2(banks);
    endfunction

endpackage

// File: rtl/bvm_agu.sv
// Vector address generator: holds one command, emits the current element
// address and advances it by the stride each time an element issues.
// Assumes: step is only asserted while active; addresses wrap at 2**ADDR_W.
module bvm_agu
    import bvm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  acc_kind_e         cmd_kind,
    input  logic [ADDR_W-1:0] cmd_start,
    input  logic [ADDR_W-1:0] cmd_stride,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              step,
    output logic              active,
    output acc_kind_e         kind,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    logic [ADDR_W-1:0] stride_q;
    logic [LEN_W-1:0]  left_q;

    assign cmd_ready = !active;

    // Command capture, address stepping and element countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            kind     <= ACC_READ;
            addr     <= '0;
            stride_q <= '0;
            left_q   <= '0;
        end else if (!active) begin
            if (cmd_valid) begin
                active   <= 1'b1;
                kind     <= cmd_kind;
                addr     <= cmd_start;
                stride_q <= cmd_stride;
                left_q   <= cmd_len;
            end
        end else if (step) begin
            if (left_q == '0) begin
                active <= 1'b0;
            end else begin
                addr   <= addr + stride_q;
                left_q <= left_q - 1'b1;
            end
        end
    end

    // Completion pulse one cycle after the final element issues.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= active && step && (left_q == '0);
    end

endmodule

// File: rtl/bvm_bank_timer.sv
// Per-bank occupancy counters: a bank hit by an access stays busy for
// BUSY_CYC cycles, counted from the edge that accepted the access.
// Assumes: at most one access per cycle; BUSY_CYC >= 1.
module bvm_bank_timer #(
    parameter int BANKS    = 16,
    parameter int BUSY_CYC = 4,
    parameter int BANK_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [BANK_W-1:0] fire_bank,
    output logic [BANKS-1:0]  busy
);

    localparam int CNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY_CYC - 1);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [CNT_W-1:0] cnt;

        // Reload on an access to this bank, otherwise count down to idle.
        always_ff @(posedge clk) begin
            if (!rst_n)                                       cnt <= '0;
            else if (fire && (fire_bank == BANK_W'(b)))       cnt <= RELOAD;
            else if (cnt != '0)                               cnt <= cnt - 1'b1;
        end

        assign busy[b] = (cnt != '0);
    end

endmodule

// File: rtl/bvm_store.sv
// Behavioural word storage with one access port and a registered read.
// Assumes: we and re are never both high; contents are not reset.
module bvm_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Single-port array access; read word is held until the next read.
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
        if (re) rdata <= cells[addr];
    end

endmodule

// File: rtl/banked_vector_mem.sv
// Top level: strided vector engine over an interleaved banked memory.
// Issues one element per cycle unless the element's bank is busy, the
// write word is missing, or the read output slot is still occupied.
// Assumes: BANKS is a power of two no larger than 2**ADDR_W.
module banked_vector_mem
    import bvm_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int LEN_W    = 8,
    parameter int BANKS    = 16,
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_start,
    input  logic [ADDR_W-1:0] cmd_stride,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              wd_valid,
    output logic              wd_ready,
    input  logic [DATA_W-1:0] wd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    localparam int BANK_W = bank_sel_w(BANKS);

    logic              active;
    acc_kind_e         kind;
    logic [ADDR_W-1:0] cur_addr;
    logic [BANK_W-1:0] issue_bank;
    logic [BANKS-1:0]  busy;
    logic              bank_free;
    logic              rd_slot;
    logic              issue;
    logic              is_write;

    assign is_write   = (kind == ACC_WRITE);
    assign issue_bank = cur_addr[BANK_W-1:0];
    assign bank_free  = !busy[issue_bank];
    assign rd_slot    = !rd_valid || rd_ready;
    assign issue      = active && bank_free && (is_write ? wd_valid : rd_slot);
    assign wd_ready   = active && is_write && bank_free;

    bvm_agu #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_agu (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_kind   (cmd_write ? ACC_WRITE : ACC_READ),
        .cmd_start  (cmd_start),
        .cmd_stride (cmd_stride),
        .cmd_len    (cmd_len),
        .step       (issue),
        .active     (active),
        .kind       (kind),
        .addr       (cur_addr),
        .done       (done)
    );

    bvm_bank_timer #(
        .BANKS    (BANKS),
        .BUSY_CYC (BUSY_CYC),
        .BANK_W   (BANK_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (issue),
        .fire_bank (issue_bank),
        .busy      (busy)
    );

    bvm_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk   (clk),
        .we    (issue && is_write),
        .re    (issue && !is_write),
        .addr  (cur_addr),
        .wdata (wd_data),
        .rdata (rd_data)
    );

    // Read output slot: filled by a read issue, emptied when taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rd_valid <= 1'b0;
        else if (issue && !is_write) rd_valid <= 1'b1;
        else if (rd_ready)           rd_valid <= 1'b0;
    end

endmodule

// File: rtl/bvm_checker.sv
// Protocol and timing checker for banked_vector_mem, attached by bind.
// Assumes: the bench holds rst_n low through the first clock edge.
module bvm_checker #(
    parameter int BANKS    = 16,
    parameter int BUSY_CYC = 4,
    parameter int DATA_W   = 16,
    parameter int BANK_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [DATA_W-1:0] rd_data,
    input logic              done,
    input logic              issue,
    input logic [BANK_W-1:0] issue_bank
);

    localparam int GAP_W = $clog2(BUSY_CYC + 1);

    for (genvar b = 0; b < BANKS; b++) begin : g_gap
        logic [GAP_W-1:0] since;

        // Cycles since this bank last accepted, saturating at BUSY_CYC.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    since <= GAP_W'(BUSY_CYC);
            else if (issue && (issue_bank == BANK_W'(b)))  since <= GAP_W'(1);
            else if (since < GAP_W'(BUSY_CYC))             since <= since + 1'b1;
        end

        assert_bank_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (issue && issue_bank == BANK_W'(b)) |-> (since >= GAP_W'(BUSY_CYC)));
    end

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_no_issue_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |-> !issue);

    assert_reset_state_R9: assert property (@(posedge clk)
        !rst_n |=> (cmd_ready && !rd_valid && !done));

endmodule

bind banked_vector_mem bvm_checker #(
    .BANKS    (BANKS),
    .BUSY_CYC (BUSY_CYC),
    .DATA_W   (DATA_W),
    .BANK_W   (BANK_W)
) u_bvm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .done       (done),
    .issue      (issue),
    .issue_bank (issue_bank)
);

// File: tb/tb_banked_vector_mem.sv
module tb_banked_vector_mem;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic [7:0]  cmd_start = '0;
    logic [7:0]  cmd_stride = '0;
    logic [7:0]  cmd_len = '0;
    logic        wd_valid = 1'b0;
    logic        wd_ready;
    logic [15:0] wd_data = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [15:0] rd_data;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    banked_vector_mem dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_write  (cmd_write),
        .cmd_start  (cmd_start),
        .cmd_stride (cmd_stride),
        .cmd_len    (cmd_len),
        .wd_valid   (wd_valid),
        .wd_ready   (wd_ready),
        .wd_data    (wd_data),
        .rd_valid   (rd_valid),
        .rd_ready   (rd_ready),
        .rd_data    (rd_data),
        .done       (done)
    );

    // Row: start, stride, count-1, expected cycles from accept to done.
    typedef struct packed {
        logic [7:0]  start;
        logic [7:0]  stride;
        logic [7:0]  lenm1;
        logic [15:0] cyc;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{start: 8'd0,   stride: 8'd1,   lenm1: 8'd15, cyc: 16'd16}, // R3
        '{start: 8'd5,   stride: 8'd3,   lenm1: 8'd9,  cyc: 16'd10}, // R3
        '{start: 8'd2,   stride: 8'd8,   lenm1: 8'd3,  cyc: 16'd6},  // R4
        '{start: 8'd7,   stride: 8'd16,  lenm1: 8'd3,  cyc: 16'd13}, // R4
        '{start: 8'd250, stride: 8'd1,   lenm1: 8'd11, cyc: 16'd12}, // R10
        '{start: 8'd9,   stride: 8'd0,   lenm1: 8'd2,  cyc: 16'd9},  // R4
        '{start: 8'd1,   stride: 8'd4,   lenm1: 8'd7,  cyc: 16'd8},  // R3
        '{start: 8'd3,   stride: 8'd24,  lenm1: 8'd3,  cyc: 16'd6},  // R4, R10
        '{start: 8'd0,   stride: 8'd255, lenm1: 8'd5,  cyc: 16'd6}   // R10
    };

    function automatic logic [15:0] pat_a(input logic [7:0] a);
        return 16'(a * 37 + 11) ^ 16'h5A00;
    endfunction

    function automatic logic [15:0] pat_b(input logic [7:0] a);
        return 16'(a * 101 + 7) ^ 16'hC3C3;
    endfunction

    function automatic logic [7:0] elem_addr(input logic [7:0] s, input logic [7:0] st, input int k);
        return 8'(int'(s) + k * int'(st));
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Offer a command at a falling edge; returns at the falling edge after acceptance.
    task automatic send_cmd(input bit wr, input logic [7:0] s, input logic [7:0] st, input logic [7:0] l);
        check(cmd_ready == 1'b1, "R6 idle ready", cmd_ready, 1);
        cmd_write = wr; cmd_start = s; cmd_stride = st; cmd_len = l; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Write vector; gap_every > 0 drops wd_valid on every such cycle.
    task automatic write_vec(input logic [7:0] s, input logic [7:0] st, input logic [7:0] l,
                             input bit use_b, input int gap_every);
        int k = 0;
        int cyc = 0;
        bit fire;
        send_cmd(1'b1, s, st, l);
        while (!done && cyc < 3000) begin
            wd_data  = use_b ? pat_b(elem_addr(s, st, k)) : pat_a(elem_addr(s, st, k));
            wd_valid = !(gap_every > 0 && (cyc % gap_every) == gap_every - 1);
            fire     = wd_valid && wd_ready;
            @(negedge clk);
            cyc++;
            if (fire) k++;
        end
        wd_valid = 1'b0;
        check(k == int'(l) + 1, "R7 write element count", k, int'(l) + 1);
        repeat (6) @(negedge clk);
    endtask

    // Read vector with rd_ready high; checks data order and completion cycle.
    task automatic read_vec(input logic [7:0] s, input logic [7:0] st, input logic [7:0] l,
                            input int exp_cyc, input bit use_b);
        int k = 0;
        int cyc = 0;
        logic [15:0] exp_d;
        rd_ready = 1'b1;
        send_cmd(1'b0, s, st, l);
        while (cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) check(wd_ready == 1'b0, "R7 no wd_ready on read", wd_ready, 0);
            if (rd_valid) begin
                exp_d = use_b ? pat_b(elem_addr(s, st, k)) : pat_a(elem_addr(s, st, k));
                check(rd_data == exp_d, "R2 R10 read data", rd_data, exp_d);
                k++;
            end
            if (done) break;
        end
        check(k == int'(l) + 1, "R2 read element count", k, int'(l) + 1);
        check(cyc == exp_cyc, "R3/R4 R1 cycles to done", cyc, exp_cyc);
        check(cmd_ready == 1'b1, "R5 ready with done", cmd_ready, 1);
        @(negedge clk);
        check(done == 1'b0, "R5 done single cycle", done, 0);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        // R9: state while and after reset
        check(cmd_ready == 1'b1, "R9 reset cmd_ready", cmd_ready, 1);
        check(rd_valid == 1'b0, "R9 reset rd_valid", rd_valid, 0);
        check(done == 1'b0, "R9 reset done", done, 0);
        check(wd_ready == 1'b0, "R9 reset wd_ready", wd_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Fill the whole memory at full rate (R3, R7).
        write_vec(8'd0, 8'd1, 8'd255, 1'b0, 0);

        // Table of strided reads.
        for (int i = 0; i < NVEC; i++)
            read_vec(VECS[i].start, VECS[i].stride, VECS[i].lenm1, int'(VECS[i].cyc), 1'b0);

        // R7: write with missing data words, then read it back.
        write_vec(8'd3, 8'd5, 8'd7, 1'b1, 3);
        read_vec(8'd3, 8'd5, 8'd7, 8, 1'b1);
        // R1 R4: stride-16 write stalls; readback confirms contents.
        write_vec(8'd40, 8'd16, 8'd2, 1'b1, 0);
        read_vec(8'd40, 8'd16, 8'd2, 9, 1'b1);

        // R8 and R6: read backpressure with a dropped command.
        rd_ready = 1'b0;
        send_cmd(1'b0, 8'd100, 8'd1, 8'd3);
        @(negedge clk);
        check(rd_valid == 1'b1, "R8 first word valid", rd_valid, 1);
        check(rd_data == pat_a(8'd100), "R8 first word", rd_data, pat_a(8'd100));
        check(cmd_ready == 1'b0, "R6 busy not ready", cmd_ready, 0);
        cmd_write = 1'b1; cmd_start = 8'd200; cmd_stride = 8'd1; cmd_len = 8'd9; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(rd_valid == 1'b1, "R8 held valid", rd_valid, 1);
        check(rd_data == pat_a(8'd100), "R8 held data", rd_data, pat_a(8'd100));
        check(done == 1'b0, "R8 no progress", done, 0);
        rd_ready = 1'b1;
        k = 1;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (rd_valid) begin
                check(rd_data == pat_a(8'(100 + k)), "R8 resumed data", rd_data, pat_a(8'(100 + k)));
                k++;
            end
            if (done) break;
        end
        check(k == 4, "R8 resumed count", k, 4);
        repeat (6) @(negedge clk);
        check(rd_valid == 1'b0, "R6 dropped cmd no read", rd_valid, 0);
        check(cmd_ready == 1'b1, "R6 dropped cmd idle", cmd_ready, 1);
        // R6: the dropped write to 200 must not have stored anything.
        read_vec(8'd200, 8'd1, 8'd0, 1, 1'b0);

        // R9: reset in the middle of a slow vector.
        send_cmd(1'b0, 8'd0, 8'd16, 8'd63);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R9 mid reset ready", cmd_ready, 1);
        check(rd_valid == 1'b0, "R9 mid reset rd_valid", rd_valid, 0);
        check(done == 1'b0, "R9 mid reset done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Bank 0 free at once after reset: one element done in 1 cycle.
        read_vec(8'd0, 8'd16, 8'd0, 1, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule